// File: doc/BRIEF.md
# Sync-Realigned Clock-Enable Divider

This block produces a one-cycle clock-enable strobe at a programmable integer fraction of the system clock. Downstream logic qualifies its registers with the strobe instead of using a derived clock. Several such dividers on one board or chip can be brought into phase by a shared sync pulse. The pulse arrives asynchronously, passes through a synchronizer, and is reduced to a single-cycle rising-edge event. If the control bits permit, that event restarts the divider's phase counter.

Three control inputs decide how sync behaves. A master enable must be high for sync to have any effect. A divider sync enable bit, held in the block, gates the pulse to the counter. A one-shot select decides between two modes. In continuous mode every permitted pulse realigns the divider. In one-shot mode only the first accepted pulse realigns it, and the sync enable bit clears itself at that moment. Software sets the enable bit through a write strobe and can read its current value back on an output.

Top module: `sgdiv_top`

## Requirements
- R1: After a synchronous reset, `div_strobe_o` and `sync_en_o` are low and the counter is at phase zero. With ratio N, the first strobe is high after the (N+1)th rising edge that follows reset release.
- R2: With no accepted sync, `div_strobe_o` is high for exactly one cycle in every N+1 cycles, where N is the 3-bit `div_ratio_i` (divide by N+1). With N=0 the strobe is high every cycle.
- R3: If `div_ratio_i` is lowered to a value at or below the current count, the counter wraps at the next edge and issues a strobe. It does not run on through the full count range.
- R4: The sync input passes through a two-flop synchronizer followed by a rising-edge detector. If a rising edge on `sync_async_i` is first sampled at clock edge k, the pulse is accepted at edge k+2. After that edge the strobe is low and the counter is at zero. The next strobe is high after N+1 further edges.
- R5: While `master_en_i` is low, sync pulses change neither the strobe phase nor `sync_en_o`.
- R6: While `sync_en_o` is low, sync pulses do not change the strobe phase.
- R7: With both enables high and `one_shot_i` low, every rising sync edge realigns the divider, and `sync_en_o` stays high.
- R8: With `one_shot_i` high, the first accepted pulse realigns the divider and clears `sync_en_o` after the accepting edge. Later pulses are ignored until software sets the bit again.
- R9: A high `sync_en_wr_i` at an edge loads `sync_en_wdata_i` into the sync enable bit. If that edge also clears the bit in one-shot mode, the clear wins.
- R10: A sync input held high realigns the divider once, at its rising edge, and not on every cycle it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio_i | input | RATIO_W (3) | Divide value N; divides by N+1 |
| master_en_i | input | 1 | Master enable for all sync functions |
| one_shot_i | input | 1 | High: only the next sync is used and the enable self-clears |
| sync_en_wr_i | input | 1 | Write strobe for the sync enable bit |
| sync_en_wdata_i | input | 1 | Value written to the sync enable bit |
| sync_async_i | input | 1 | Asynchronous sync pulse input |
| div_strobe_o | output | 1 | Registered divided clock-enable strobe |
| sync_en_o | output | 1 | Current divider sync enable bit |

## Verification
The bench runs a cycle-accurate reference model in lockstep with the design, feeding both with directed phases and then seeded random traffic. It measures the exact two-cycle acceptance latency after a sync edge. A design with one synchronizer stage too many or too few would place every realigned strobe one cycle off. The bench holds sync high for many cycles, which exposes a level-sensitive detector that keeps restarting the counter and never strobes. It lowers the ratio under a running count, which exposes an equality-only wrap that would stall for up to eight cycles. It also lands a software write on the exact edge of a one-shot clear, which exposes a write-over-clear priority that leaves the enable stuck high.

// File: rtl/sgdiv_pkg.sv
package sgdiv_pkg;

  // Control bundle handed from the top to the sync gate.
  typedef struct packed {
    logic master_en;
    logic one_shot;
    logic wr;
    logic wdata;
  } sync_ctrl_t;

endpackage

// File: rtl/sgdiv_edge.sv
module sgdiv_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("sgdiv_edge needs at least two synchronizer stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], sync_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // A detected edge lasts exactly one cycle.
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("edge event wider than one cycle"); // R10

endmodule

// File: rtl/sgdiv_gate.sv
module sgdiv_gate
  import sgdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise_i,
  input  sync_ctrl_t ctrl_i,
  output logic       accept_o,
  output logic       sync_en_o
);

  logic sync_en_q;
  logic self_clear;

  assign accept_o   = rise_i & ctrl_i.master_en & sync_en_q;
  assign self_clear = accept_o & ctrl_i.one_shot;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_en_q <= 1'b0;
    end else if (self_clear) begin
      sync_en_q <= 1'b0;
    end else if (ctrl_i.wr) begin
      sync_en_q <= ctrl_i.wdata;
    end
  end

  assign sync_en_o = sync_en_q;

  AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (accept_o && ctrl_i.one_shot) |=> !sync_en_q) else $error("one-shot did not clear"); // R8

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.wr && !(accept_o && ctrl_i.one_shot)) |=> (sync_en_q == $past(ctrl_i.wdata)))
    else $error("enable write lost"); // R9

  AST_MASTER_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i.master_en && !ctrl_i.wr) |=> $stable(sync_en_q)) else $error("enable moved with master off"); // R5

endmodule

// File: rtl/sgdiv_phase.sv
module sgdiv_phase #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               restart_i,
  output logic               strobe_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic               strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (cnt_q >= ratio_i) begin
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (cnt_q == '0)) else $error("strobe away from phase zero"); // R2

  AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0 && !strobe_q)) else $error("restart did not realign"); // R4

endmodule

// File: rtl/sgdiv_top.sv
module sgdiv_top
  import sgdiv_pkg::*;
#(
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] div_ratio_i,
  input  logic               master_en_i,
  input  logic               one_shot_i,
  input  logic               sync_en_wr_i,
  input  logic               sync_en_wdata_i,
  input  logic               sync_async_i,
  output logic               div_strobe_o,
  output logic               sync_en_o
);

  logic       rise;
  logic       accept;
  sync_ctrl_t ctrl;

  assign ctrl.master_en = master_en_i;
  assign ctrl.one_shot  = one_shot_i;
  assign ctrl.wr        = sync_en_wr_i;
  assign ctrl.wdata     = sync_en_wdata_i;

  sgdiv_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_async_i),
    .rise_o (rise)
  );

  sgdiv_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .ctrl_i    (ctrl),
    .accept_o  (accept),
    .sync_en_o (sync_en_o)
  );

  sgdiv_phase #(.RATIO_W(RATIO_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .ratio_i   (div_ratio_i),
    .restart_i (accept),
    .strobe_o  (div_strobe_o)
  );

  AST_NO_RESTART_SYNC_OFF: assert property (@(posedge clk) disable iff (rst)
    !sync_en_o |-> !accept) else $error("restart while enable low"); // R6

endmodule

// File: tb/sgdiv_top_test.sv
module sgdiv_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio = 3'd0;
  logic       master = 1'b0, one_shot = 1'b0, wr = 1'b0, wdata = 1'b0, sync = 1'b0;
  logic       strobe, sync_en;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  sgdiv_top uut (
    .clk(clk), .rst(rst), .div_ratio_i(ratio), .master_en_i(master),
    .one_shot_i(one_shot), .sync_en_wr_i(wr), .sync_en_wdata_i(wdata),
    .sync_async_i(sync), .div_strobe_o(strobe), .sync_en_o(sync_en)
  );

  // Reference model built from the requirements.
  int unsigned m_cnt = 0;
  bit m_str = 0, m_en = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;
  bit m_acc;

  function automatic bit accept_now();
    return m_s2 && !m_s3 && master && m_en;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_str = 0; m_en = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      m_acc = accept_now();
      if (m_acc && one_shot) m_en = 0;
      else if (wr) m_en = wdata;
      if (m_acc) begin m_cnt = 0; m_str = 0; end
      else if (m_cnt >= ratio) begin m_cnt = 0; m_str = 1; end
      else begin m_cnt = m_cnt + 1; m_str = 0; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync;
    end
  end

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(tag, "strobe", strobe, m_str);
    chk(tag, "sync_en", sync_en, m_en);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic write_en(input bit v);
    wr = 1; wdata = v; cyc(); wr = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    sync = 1; run(hi); sync = 0; run(lo);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "reset strobe", strobe, 0);
    chk("R1", "reset sync_en", sync_en, 0);
    ratio = 3'd3;
    rst = 0;
    // R1: first strobe after edge N+1 = 4
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R1", "first strobe", strobe, (i == 4) ? 1 : 0);
    end
    // R2: N=0 passes every cycle
    tag = "R2"; ratio = 3'd0; cyc();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2", "N=0 strobe", strobe, 1);
    end
    // R2: N=5 rate
    ratio = 3'd5; run(6);
    n = 0;
    for (int i = 0; i < 60; i++) begin cyc(); n += strobe; end
    chk("R2", "strobes in 60 cycles at N=5", n, 10);
    // R3: lower ratio under a high count
    tag = "R3"; ratio = 3'd7;
    while (m_cnt != 6) cyc();
    ratio = 3'd1;
    @(negedge clk);
    chk("R3", "wrap after ratio drop", strobe, 1);
    run(10);
    // R5: master off
    tag = "R5"; master = 0; write_en(1); run(3);
    ratio = 3'd6; pulse(3, 12); pulse(1, 9);
    chk("R5", "sync_en kept", sync_en, 1);
    // R6: divider enable off
    tag = "R6"; master = 1; write_en(0); run(2);
    pulse(2, 11); pulse(5, 7);
    // R4 latency with continuous mode
    tag = "R4"; ratio = 3'd7; one_shot = 0; write_en(1);
    while (m_cnt != 3) cyc();
    sync = 1;
    run(3);
    chk("R4", "strobe low after accept", strobe, 0);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R4", "realigned strobe", strobe, (i == 8) ? 1 : 0);
    end
    sync = 0; run(4);
    // R7: repeated pulses, continuous
    tag = "R7";
    for (int i = 0; i < 5; i++) pulse(1 + i, 5 + 2 * i);
    chk("R7", "sync_en stays", sync_en, 1);
    // R10: held high
    tag = "R10"; sync = 1; run(40);
    n = 0;
    for (int i = 0; i < 16; i++) begin cyc(); n += strobe; end
    chk("R10", "strobes while sync held", n, 2);
    sync = 0; run(5);
    // R8: one-shot
    tag = "R8"; one_shot = 1; run(2);
    pulse(2, 6);
    chk("R8", "self clear", sync_en, 0);
    pulse(2, 10);
    // R9: write colliding with clear
    tag = "R9"; write_en(1); run(2);
    sync = 1;
    while (!accept_now()) cyc();
    wr = 1; wdata = 1; cyc(); wr = 0;
    chk("R9", "clear beats write", sync_en, 0);
    sync = 0; run(3);
    write_en(1);
    chk("R9", "write loads", sync_en, 1);
    // Random mix
    tag = "random R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) sync = ~sync;
      if ($urandom_range(0, 60) == 0) ratio = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 40) == 0) master = ~master;
      if ($urandom_range(0, 50) == 0) one_shot = ~one_shot;
      wr = ($urandom_range(0, 15) == 0);
      wdata = ($urandom_range(0, 3) != 0);
      cyc();
    end
    wr = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule